// File: doc/BRIEF.md
# Three-Wire Serial Control Word Receiver

This block takes control words from a host over three wires: an enable line, a serial clock and a data line. A frame has two phases. While enable is low, the host clocks in an 8-bit device address. The first bit it sends lands in address position 0. The host then raises enable and clocks in 96 control bits. When enable falls, the block checks the frame. If the address matched and exactly 96 control bits arrived, it copies the whole collected word into a shadow control register in a single step. It also raises a strobe for one system clock cycle.

All three wires are asynchronous to the system clock. Each passes through a two-flop synchroniser and is edge-detected in the system clock domain, so the system clock must run at least 8 times faster than the serial clock. Serial bits are taken on rising edges of the serial clock. The latched word never shows a half-written frame: between commits it holds its previous value. What the control fields mean is outside this block.

Top module: `serial_ctl_rx`

## Requirements
- R1: After reset, `ctl_word` is all zeros and `ctl_new` is low.
- R2: While `ser_en` is low, each rising edge of `ser_clk` shifts `ser_dat` into the address collector, and the first bit sent takes address position 0. The only accepted device address is the bit sequence 1,0,0,0,0,0,0,1 in sending order.
- R3: While `ser_en` is high, each rising edge of `ser_clk` shifts one control bit into the collector. The first bit sent ends up in `ctl_word[0]` and the 96th bit ends up in `ctl_word[95]`.
- R4: A valid frame becomes visible at the falling edge of `ser_en`. Within 4 system clock cycles of the pin edge, `ctl_word` takes the new word and `ctl_new` is high for exactly one cycle.
- R5: If the address sequence does not match, the falling edge of `ser_en` leaves `ctl_word` unchanged and produces no strobe.
- R6: If fewer than 96 control bits were received, the falling edge of `ser_en` leaves `ctl_word` unchanged and produces no strobe.
- R7: If more than 96 control bits were received, the falling edge of `ser_en` leaves `ctl_word` unchanged and produces no strobe.
- R8: An address phase must contain exactly 8 bits, or the frame is rejected. The address collector is emptied at every rising edge of `ser_en`, so bits from an earlier, aborted address phase never combine with later ones.
- R9: `ctl_word` changes only when `ctl_new` is high. Back-to-back valid frames each commit their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_en | input | 1 | Frame enable wire (low: address phase, high: data phase) |
| ser_clk | input | 1 | Serial bit clock, sampled on rising edges |
| ser_dat | input | 1 | Serial data wire |
| ctl_word | output | 96 | Latched control word |
| ctl_new | output | 1 | One-cycle strobe when a new word is latched |

## Verification
The assertions assume that `ser_en` never changes in the same synchronised cycle as a rising edge of `ser_clk`. They also assume that every serial clock level lasts several system clocks. These two conditions make each edge event a single isolated cycle, so the one-cycle strobe and commit-gating properties hold. The stimulus keeps each serial clock half-period at 8 system clocks. It changes `ser_dat` and `ser_en` only while `ser_clk` is low, and it leaves 8 idle system clocks around every enable transition.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 96;
  // first-sent bit at position 0: sequence 1,0,0,0,0,0,0,1
  parameter logic [ADDR_W-1:0] DEV_ID = 8'h81;
  // lanes of the input synchroniser
  parameter int LN_EN  = 0;
  parameter int LN_CLK = 1;
  parameter int LN_DAT = 2;
  parameter int N_LANE = 3;
endpackage

// File: rtl/serial_ctl_sync.sv
module serial_ctl_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] meta_q, sync_q, dly_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        dly_q[g]  <= 1'b0;
      end else begin
        meta_q[g] <= raw[g];
        sync_q[g] <= meta_q[g];
        dly_q[g]  <= sync_q[g];
      end
    end
    assign lvl[g]  = sync_q[g];
    assign rise[g] = sync_q[g] & ~dly_q[g];
    assign fall[g] = ~sync_q[g] & dly_q[g];
  end
endmodule

// File: rtl/serial_ctl_addr.sv
module serial_ctl_addr #(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ID = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_lvl,
  input  logic en_rise,
  input  logic bit_stb,
  input  logic bit_val,
  output logic addr_ok
);
  localparam int CNT_W   = $clog2(ADDR_W + 2);
  localparam int CNT_CAP = ADDR_W + 1;

  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ok_q, ok_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    ok_d  = ok_q;
    if (en_rise) begin
      ok_d  = (cnt_q == CNT_W'(ADDR_W)) && (sh_q == DEV_ID);
      sh_d  = '0;
      cnt_d = '0;
    end else if (bit_stb && !en_lvl) begin
      sh_d = {bit_val, sh_q[ADDR_W-1:1]};
      if (cnt_q != CNT_W'(CNT_CAP)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign addr_ok = ok_q;

  // R8
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (cnt_q == '0) && (sh_q == '0));
endmodule

// File: rtl/serial_ctl_data.sv
module serial_ctl_data #(
  parameter int DATA_W = 96
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en_lvl,
  input  logic                         en_rise,
  input  logic                         bit_stb,
  input  logic                         bit_val,
  output logic [DATA_W-1:0]            word,
  output logic [$clog2(DATA_W+2)-1:0]  cnt
);
  localparam int CNT_W   = $clog2(DATA_W + 2);
  localparam int CNT_CAP = DATA_W + 1;

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (en_rise) begin
      cnt_d = '0;
    end else if (bit_stb && en_lvl) begin
      sh_d = {bit_val, sh_q[DATA_W-1:1]};
      if (cnt_q != CNT_W'(CNT_CAP)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign word = sh_q;
  assign cnt  = cnt_q;

  // R3
  data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_lvl && !en_rise) |=> $stable(cnt_q));
endmodule

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx
  import serial_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [DATA_W-1:0] ctl_word,
  output logic              ctl_new
);
  localparam int DCNT_W = $clog2(DATA_W + 2);

  logic              rst_a_q, rst_b_q, rst_sn;
  logic [N_LANE-1:0] raw, lvl, rise, fall;
  logic              bit_stb, addr_ok;
  logic [DATA_W-1:0] col_word;
  logic [DCNT_W-1:0] col_cnt;
  logic [DATA_W-1:0] word_q, word_d;
  logic              new_q, new_d, commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  assign rst_sn = rst_b_q;

  assign raw[LN_EN]  = ser_en;
  assign raw[LN_CLK] = ser_clk;
  assign raw[LN_DAT] = ser_dat;

  serial_ctl_sync #(.N(N_LANE)) i_sync (
    .clk(clk), .rst_n(rst_sn), .raw(raw), .lvl(lvl), .rise(rise), .fall(fall)
  );

  // a serial clock edge coinciding with an enable edge is dropped
  assign bit_stb = rise[LN_CLK] & ~rise[LN_EN] & ~fall[LN_EN];

  serial_ctl_addr #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) i_addr (
    .clk(clk), .rst_n(rst_sn), .en_lvl(lvl[LN_EN]), .en_rise(rise[LN_EN]),
    .bit_stb(bit_stb), .bit_val(lvl[LN_DAT]), .addr_ok(addr_ok)
  );

  serial_ctl_data #(.DATA_W(DATA_W)) i_data (
    .clk(clk), .rst_n(rst_sn), .en_lvl(lvl[LN_EN]), .en_rise(rise[LN_EN]),
    .bit_stb(bit_stb), .bit_val(lvl[LN_DAT]), .word(col_word), .cnt(col_cnt)
  );

  assign commit = fall[LN_EN] && addr_ok && (col_cnt == DCNT_W'(DATA_W));

  always_comb begin
    word_d = word_q;
    new_d  = 1'b0;
    if (commit) begin
      word_d = col_word;
      new_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      word_q <= '0;
      new_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      new_q  <= new_d;
    end
  end

  assign ctl_word = word_q;
  assign ctl_new  = new_q;

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    new_q |=> !new_q);
  // R5 R6 R7
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    new_q |-> $past(addr_ok && (col_cnt == DCNT_W'(DATA_W)) && fall[LN_EN]));
  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !new_q |-> $stable(word_q));
endmodule

// File: tb/test_serial_ctl_rx.sv
`timescale 1ns/1ps
module test_serial_ctl_rx;
  localparam int DW = 96;
  localparam int HP = 8;

  logic clk, rst_n, ser_en, ser_clk, ser_dat;
  logic [DW-1:0] ctl_word;
  logic ctl_new;

  int total = 0, bad = 0, nstb = 0;
  logic [DW-1:0] exp_word;
  bit done = 0;

  serial_ctl_rx i_serial_ctl_rx (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .ctl_word(ctl_word), .ctl_new(ctl_new)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) if (ctl_new) nstb++;

  localparam logic [15:0] GOOD_ADDR = 16'h0081;
  localparam logic [15:0] BAD_ADDR  = 16'h0041;

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_clk(HP);
    ser_clk = 1'b1;
    wait_clk(HP);
    ser_clk = 1'b0;
  endtask

  task automatic frame(input logic [15:0] ab, input int na,
                       input logic [127:0] db, input int nd);
    ser_en = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < na; i++) send_bit(ab[i]);
    wait_clk(HP);
    ser_en = 1'b1;
    wait_clk(HP);
    for (int i = 0; i < nd; i++) send_bit(db[i]);
    wait_clk(HP);
    ser_en = 1'b0;
    wait_clk(HP);
  endtask

  task automatic check(input string req, input logic [DW-1:0] ew,
                       input int estb, input int stb0);
    total++;
    if (ctl_word !== ew || (nstb - stb0) != estb) begin
      bad++;
      $display("FAIL %s word=%h exp=%h strobes=%0d exp=%0d",
               req, ctl_word, ew, nstb - stb0, estb);
    end
  endtask

  task automatic t_reset;
    total++;
    if (ctl_word !== '0 || ctl_new !== 1'b0) begin
      bad++;
      $display("FAIL R1 word=%h exp=0 new=%b exp=0", ctl_word, ctl_new);
    end
  endtask

  task automatic t_good(input string req, input logic [DW-1:0] w);
    int s0 = nstb;
    frame(GOOD_ADDR, 8, {32'h0, w}, DW);
    exp_word = w;
    check(req, exp_word, 1, s0);
  endtask

  task automatic t_timing;
    int s0 = nstb;
    int seen_at = -1;
    logic [DW-1:0] w = {32'h5A5A_0F0F, 32'hC3C3_9696, 32'h1248_8421};
    ser_en = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < 8; i++) send_bit(GOOD_ADDR[i]);
    wait_clk(HP);
    ser_en = 1'b1;
    wait_clk(HP);
    for (int i = 0; i < DW; i++) send_bit(w[i]);
    wait_clk(HP);
    ser_en = 1'b0;
    for (int c = 1; c <= 6; c++) begin
      wait_clk(1);
      if (ctl_new && seen_at < 0) seen_at = c;
    end
    total++;
    if (seen_at < 1 || seen_at > 4) begin
      bad++;
      $display("FAIL R4 strobe at cycle %0d exp 1..4", seen_at);
    end
    exp_word = w;
    check("R4", exp_word, 1, s0);
  endtask

  task automatic t_reject(input string req, input logic [15:0] ab, input int na,
                          input logic [DW-1:0] w, input int nd);
    int s0 = nstb;
    frame(ab, na, {32'h0, w}, nd);
    check(req, exp_word, 0, s0);
  endtask

  task automatic t_split_addr;
    int s0 = nstb;
    frame(GOOD_ADDR, 4, 128'h0, 0);
    frame(GOOD_ADDR >> 4, 4, {32'h0, 96'hFFFF}, DW);
    check("R8 split", exp_word, 0, s0);
  endtask

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] p1;
    rst_n = 0; ser_en = 0; ser_clk = 0; ser_dat = 0;
    p1 = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF};
    exp_word = '0;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    t_reset();
    t_good("R2 R3 pattern", p1);
    t_good("R3 first bit to position 0", 96'h1);
    t_good("R3 last bit to position 95", {1'b1, 95'h0});
    t_good("R9 second word", ~p1);
    t_reject("R5 wrong address", BAD_ADDR, 8, 96'h0, DW);
    t_reject("R6 short 95", GOOD_ADDR, 8, p1, DW - 1);
    t_reject("R6 empty data", GOOD_ADDR, 8, p1, 0);
    t_reject("R7 long 97", GOOD_ADDR, 8, p1, DW + 1);
    t_reject("R8 seven addr bits", GOOD_ADDR, 7, p1, DW);
    t_reject("R8 nine addr bits", GOOD_ADDR << 1, 9, p1, DW);
    t_split_addr();
    t_good("R8 recovery", 96'h0F0F_0000_1234_5678_9ABC_DEF0);
    t_timing();
    t_good("R9 back-to-back", p1 ^ {DW{1'b1}} ^ 96'h3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule